// File: doc/BRIEF.md
# Activity Monitor with Watermark Interrupts

The block watches a set of activity event lines, one per channel, and turns them into a per-period activity figure. A shared timer divides an external millisecond tick into sampling periods. Within each period, every event seen by an enabled channel adds that channel's programmable weight to an accumulator. When the period closes, the accumulated total becomes that channel's sample and the accumulator restarts from zero.

Each channel keeps an exponential moving average of its samples. The window length is a power of two set by a control field. Status flags latch when the average leaves a programmable band. They also latch when the raw sample stays above the upper watermark, or below the lower watermark, for a programmed number of periods in a row. Flags are cleared by writing ones. A gated interrupt line and a global summary register report which channels have a pending, enabled flag.

Software drives everything through a simple register bus. Writes take effect on the clock edge, and reads are combinational from the address.

Top module: `actmon_top`

## Requirements
- R1: After reset every register reads zero, with two exceptions. The count weight reads 1024 and the period register (address 0x004) reads 11. The irq output is low.
- R2: The period register holds the period length minus one, counted in ms_tick pulses. The sample closes on the tick that brings the count to register+1. The average therefore does not move after only register ticks.
- R3: While a channel is not active, its events are ignored. Active means control bit 31 (master enable) and bit 18 (periodic sampling) are both set. The accumulator stays empty, and the average and status do not change at period ends.
- R4: At each period end of an active channel, avg becomes avg + ((sample - avg) >>> (K+1)), computed as a signed difference with an arithmetic shift. K is control bits 12:10, and the average is readable at offset 0x20.
- R5: A control write that sets bit 31 while it was clear loads the average from the initial-average register (offset 0x0C).
- R6: At a period end, status bit 29 is set if the new average exceeds the average-upper register (0x10). Status bit 28 is set if the new average is below the average-lower register (0x14). Bits 21 and 20 gate these flags onto the interrupt.
- R7: When control bit 30 is set, status bit 31 is set on the Nth consecutive sample greater than the upper watermark (0x04). N is control bits 28:26 plus one. A sample not above the watermark restarts the run, and so does clearing bit 30 or deactivating the channel.
- R8: When control bit 29 is set, status bit 30 is set on the Nth consecutive sample below the lower watermark (0x08). N is control bits 25:23 plus one, and the run restarts in the same ways as in R7.
- R9: Writing the status register (0x24) clears each bit written as one. A flag raised in the same cycle as the write still gets set.
- R10: The summary register (0x000) shows channel c's gated interrupt on bit 26-c, and irq is the OR of all channels. A channel's gated interrupt is status bits 31/30/29/28 ANDed with control bits 30/29/21/20.
- R11: Channel c's registers sit at 0x1C0 + 0x40*c. The offsets are: control 0x00, weight 0x18, and the others as named in R4 to R9.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ms_tick | input | 1 | One-cycle time-base pulse that advances the period timer |
| event_in | input | NCH | Per-channel activity event, one per cycle |
| bus_addr | input | AW | Register byte address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq | output | 1 | OR of every channel's enabled pending flags |

## Verification
The directed phase runs one channel through several patterns. A short run of three high samples must fire the upper flag on exactly the third sample. A high, low, high, high pattern must not fire, which shows the run restarts. A burst with periodic sampling cleared shows that idle channels ignore events. A second channel held at zero activity tells the average-below flag apart from the consecutive-below flag, because the two latch one period apart. The random phase then mixes event density, tick rate, weights, window sizes, watermarks, partial status clears and re-enables against a bench model. This catches errors in rounding of the negative average step, in accumulator clearing and in set-versus-clear priority.

// File: rtl/actmon_pkg.sv
// Shared constants for the activity monitor: control and status field
// positions that software relies on, and register offsets.
package actmon_pkg;
    // control register fields
    localparam int CTL_K_LSB      = 10;
    localparam int CTL_K_W        = 3;
    localparam int CTL_PERIODIC   = 18;
    localparam int CTL_AVG_LO_EN  = 20;
    localparam int CTL_AVG_HI_EN  = 21;
    localparam int CTL_RUN_LO_LSB = 23;
    localparam int CTL_RUN_HI_LSB = 26;
    localparam int RUN_W          = 3;
    localparam int CTL_RUN_LO_EN  = 29;
    localparam int CTL_RUN_HI_EN  = 30;
    localparam int CTL_ENABLE     = 31;

    // status register flags
    localparam int ST_RUN_HI = 31;
    localparam int ST_RUN_LO = 30;
    localparam int ST_AVG_HI = 29;
    localparam int ST_AVG_LO = 28;

    // per-channel register offsets
    localparam int OFS_CTRL    = 'h00;
    localparam int OFS_WM_HI   = 'h04;
    localparam int OFS_WM_LO   = 'h08;
    localparam int OFS_INIT    = 'h0C;
    localparam int OFS_AVG_HI  = 'h10;
    localparam int OFS_AVG_LO  = 'h14;
    localparam int OFS_WEIGHT  = 'h18;
    localparam int OFS_AVG     = 'h20;
    localparam int OFS_STATUS  = 'h24;

    // global register offsets
    localparam int GLB_SUMMARY = 'h000;
    localparam int GLB_PERIOD  = 'h004;
endpackage

// File: rtl/actmon_period.sv
// Period timer: counts ms_tick pulses and emits a one-cycle period_end on
// the tick that completes limit+1 ticks. Assumes tick is a single-cycle
// strobe; a limit lowered below the running count ends the period at once.
module actmon_period #(
    parameter int PW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [PW-1:0] limit,
    output logic          period_end
);
    logic [PW-1:0] cnt_q;

    assign period_end = tick && (cnt_q >= limit);

    // advance the tick count, wrapping at the end of each period
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (tick) begin
            cnt_q <= period_end ? '0 : cnt_q + 1'b1;
        end
    end
endmodule

// File: rtl/actmon_streak.sv
// Consecutive-sample counter: fires on the sample that makes a run of
// need+1 hits in a row. Assumes strobe marks one sample per pulse; the run
// restarts on a miss or whenever enable drops, and saturates while firing.
module actmon_streak #(
    parameter int CW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          strobe,
    input  logic          hit,
    input  logic [CW-1:0] need,
    output logic          fire
);
    logic [CW-1:0] run_q;

    assign fire = enable && strobe && hit && (run_q == need);

    // track the length of the current run of hits
    always_ff @(posedge clk) begin
        if (!rst_n || !enable) begin
            run_q <= '0;
        end else if (strobe) begin
            if (!hit) begin
                run_q <= '0;
            end else if (run_q != need) begin
                run_q <= run_q + 1'b1;
            end
        end
    end
endmodule

// File: rtl/actmon_channel.sv
// One monitor channel: register file, weighted event accumulator, moving
// average, watermark comparators and the two consecutive-sample counters.
// Assumes wr_en is already qualified by the channel's address range.
module actmon_channel
    import actmon_pkg::*;
#(
    parameter int          OFS_W      = 6,
    parameter logic [31:0] WEIGHT_RST = 32'd1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             period_end,
    input  logic             event_in,
    input  logic             wr_en,
    input  logic [OFS_W-1:0] ofs,
    input  logic [31:0]      wdata,
    output logic [31:0]      rdata,
    output logic             irq_o
);
    localparam logic [OFS_W-1:0] A_CTRL   = OFS_W'(OFS_CTRL);
    localparam logic [OFS_W-1:0] A_WM_HI  = OFS_W'(OFS_WM_HI);
    localparam logic [OFS_W-1:0] A_WM_LO  = OFS_W'(OFS_WM_LO);
    localparam logic [OFS_W-1:0] A_INIT   = OFS_W'(OFS_INIT);
    localparam logic [OFS_W-1:0] A_AVG_HI = OFS_W'(OFS_AVG_HI);
    localparam logic [OFS_W-1:0] A_AVG_LO = OFS_W'(OFS_AVG_LO);
    localparam logic [OFS_W-1:0] A_WEIGHT = OFS_W'(OFS_WEIGHT);
    localparam logic [OFS_W-1:0] A_AVG    = OFS_W'(OFS_AVG);
    localparam logic [OFS_W-1:0] A_STATUS = OFS_W'(OFS_STATUS);

    logic [31:0] ctrl_q, wm_hi_q, wm_lo_q, init_q, avg_hi_q, avg_lo_q, weight_q;
    logic [31:0] avg_q, status_q, acc_q;

    logic               active, seed, take;
    logic [32:0]        acc_sum;
    logic [31:0]        acc_sat;
    logic signed [32:0] diff, step;
    logic [3:0]         shamt;
    logic [31:0]        avg_upd;
    logic [31:0]        set_vec, gate_vec;
    logic [1:0]         s_en, s_hit, s_fire;
    logic [RUN_W-1:0]   s_need [2];

    assign active  = ctrl_q[CTL_ENABLE] && ctrl_q[CTL_PERIODIC];
    assign take    = period_end && active;
    assign seed    = wr_en && (ofs == A_CTRL) && wdata[CTL_ENABLE] && !ctrl_q[CTL_ENABLE];
    assign acc_sum = {1'b0, acc_q} + ((active && event_in) ? {1'b0, weight_q} : 33'd0);
    assign acc_sat = acc_sum[32] ? 32'hFFFF_FFFF : acc_sum[31:0];
    assign shamt   = {1'b0, ctrl_q[CTL_K_LSB +: CTL_K_W]} + 4'd1;
    assign diff    = $signed({1'b0, acc_sat}) - $signed({1'b0, avg_q});
    assign step    = diff >>> shamt;
    assign avg_upd = avg_q + step[31:0];

    // per-direction inputs of the consecutive-sample counters
    assign s_en[0]   = ctrl_q[CTL_RUN_HI_EN] && active;
    assign s_hit[0]  = acc_sat > wm_hi_q;
    assign s_need[0] = ctrl_q[CTL_RUN_HI_LSB +: RUN_W];
    assign s_en[1]   = ctrl_q[CTL_RUN_LO_EN] && active;
    assign s_hit[1]  = acc_sat < wm_lo_q;
    assign s_need[1] = ctrl_q[CTL_RUN_LO_LSB +: RUN_W];

    for (genvar d = 0; d < 2; d++) begin : g_streak
        actmon_streak #(.CW(RUN_W)) u_streak (
            .clk    (clk),
            .rst_n  (rst_n),
            .enable (s_en[d]),
            .strobe (period_end),
            .hit    (s_hit[d]),
            .need   (s_need[d]),
            .fire   (s_fire[d])
        );
    end

    // collect the flags raised this cycle and the interrupt gates
    always_comb begin
        set_vec              = '0;
        set_vec[ST_RUN_HI]   = s_fire[0];
        set_vec[ST_RUN_LO]   = s_fire[1];
        set_vec[ST_AVG_HI]   = take && (avg_upd > avg_hi_q);
        set_vec[ST_AVG_LO]   = take && (avg_upd < avg_lo_q);
        gate_vec             = '0;
        gate_vec[ST_RUN_HI]  = ctrl_q[CTL_RUN_HI_EN];
        gate_vec[ST_RUN_LO]  = ctrl_q[CTL_RUN_LO_EN];
        gate_vec[ST_AVG_HI]  = ctrl_q[CTL_AVG_HI_EN];
        gate_vec[ST_AVG_LO]  = ctrl_q[CTL_AVG_LO_EN];
    end

    assign irq_o = |(status_q & gate_vec);

    // software-written configuration registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q   <= '0;
            wm_hi_q  <= '0;
            wm_lo_q  <= '0;
            init_q   <= '0;
            avg_hi_q <= '0;
            avg_lo_q <= '0;
            weight_q <= WEIGHT_RST;
        end else if (wr_en) begin
            case (ofs)
                A_CTRL:   ctrl_q   <= wdata;
                A_WM_HI:  wm_hi_q  <= wdata;
                A_WM_LO:  wm_lo_q  <= wdata;
                A_INIT:   init_q   <= wdata;
                A_AVG_HI: avg_hi_q <= wdata;
                A_AVG_LO: avg_lo_q <= wdata;
                A_WEIGHT: weight_q <= wdata;
                default:  ;
            endcase
        end
    end

    // accumulate weighted events and restart at each period end
    always_ff @(posedge clk) begin
        if (!rst_n || !active || take) begin
            acc_q <= '0;
        end else begin
            acc_q <= acc_sat;
        end
    end

    // seed or update the moving average
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            avg_q <= '0;
        end else if (seed) begin
            avg_q <= init_q;
        end else if (take) begin
            avg_q <= avg_upd;
        end
    end

    // sticky status flags with write-one-to-clear, set winning
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            status_q <= '0;
        end else if (wr_en && (ofs == A_STATUS)) begin
            status_q <= (status_q & ~wdata) | set_vec;
        end else begin
            status_q <= status_q | set_vec;
        end
    end

    // combinational read mux
    always_comb begin
        case (ofs)
            A_CTRL:   rdata = ctrl_q;
            A_WM_HI:  rdata = wm_hi_q;
            A_WM_LO:  rdata = wm_lo_q;
            A_INIT:   rdata = init_q;
            A_AVG_HI: rdata = avg_hi_q;
            A_AVG_LO: rdata = avg_lo_q;
            A_WEIGHT: rdata = weight_q;
            A_AVG:    rdata = avg_q;
            A_STATUS: rdata = status_q;
            default:  rdata = '0;
        endcase
    end
endmodule

// File: rtl/actmon_top.sv
// Activity monitor top: shared period timer, address decode into NCH
// channel windows, summary register and the combined interrupt.
// Assumes the channel window size is a power of two and windows do not
// overlap the global registers.
module actmon_top
    import actmon_pkg::*;
#(
    parameter int          NCH          = 2,
    parameter int          AW           = 12,
    parameter int          PW           = 8,
    parameter logic [PW-1:0] PERIOD_RST = 8'd11,
    parameter logic [31:0] WEIGHT_RST   = 32'd1024,
    parameter int          CH_BASE      = 'h1C0,
    parameter int          CH_SPAN_LOG2 = 6,
    parameter int          SUM_TOP_BIT  = 26
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ms_tick,
    input  logic [NCH-1:0] event_in,
    input  logic [AW-1:0]  bus_addr,
    input  logic           bus_wr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic           irq
);
    localparam int IDX_W    = AW - CH_SPAN_LOG2;
    localparam int CH_IDX0  = CH_BASE >> CH_SPAN_LOG2;
    localparam logic [AW-1:0] A_SUMMARY = AW'(GLB_SUMMARY);
    localparam logic [AW-1:0] A_PERIOD  = AW'(GLB_PERIOD);

    logic [PW-1:0]  period_q;
    logic           period_end;
    logic [NCH-1:0] ch_sel, ch_irq;
    logic [31:0]    ch_rdata [NCH];
    logic [31:0]    summary;

    // period-length register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            period_q <= PERIOD_RST;
        end else if (bus_wr && (bus_addr == A_PERIOD)) begin
            period_q <= bus_wdata[PW-1:0];
        end
    end

    actmon_period #(.PW(PW)) u_period (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (ms_tick),
        .limit      (period_q),
        .period_end (period_end)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_ch
        localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(CH_IDX0 + c);
        assign ch_sel[c] = (bus_addr[AW-1:CH_SPAN_LOG2] == MY_IDX);

        actmon_channel #(
            .OFS_W      (CH_SPAN_LOG2),
            .WEIGHT_RST (WEIGHT_RST)
        ) u_ch (
            .clk        (clk),
            .rst_n      (rst_n),
            .period_end (period_end),
            .event_in   (event_in[c]),
            .wr_en      (bus_wr && ch_sel[c]),
            .ofs        (bus_addr[CH_SPAN_LOG2-1:0]),
            .wdata      (bus_wdata),
            .rdata      (ch_rdata[c]),
            .irq_o      (ch_irq[c])
        );
    end

    // place each channel's interrupt in the summary word
    always_comb begin
        summary = '0;
        for (int c = 0; c < NCH; c++) begin
            summary[SUM_TOP_BIT - c] = ch_irq[c];
        end
    end

    assign irq = |ch_irq;

    // global read mux
    always_comb begin
        bus_rdata = '0;
        if (bus_addr == A_SUMMARY) begin
            bus_rdata = summary;
        end else if (bus_addr == A_PERIOD) begin
            bus_rdata = 32'(period_q);
        end
        for (int c = 0; c < NCH; c++) begin
            if (ch_sel[c]) begin
                bus_rdata = ch_rdata[c];
            end
        end
    end
endmodule

// File: rtl/actmon_channel_checker.sv
// Temporal checks on each monitor channel, bound into every instance.
module actmon_channel_checker
    import actmon_pkg::*;
#(
    parameter int OFS_W = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_end,
    input logic             active,
    input logic             seed,
    input logic             wr_en,
    input logic [OFS_W-1:0] ofs,
    input logic [31:0]      wdata,
    input logic [31:0]      status_q,
    input logic [31:0]      avg_q,
    input logic [31:0]      acc_q,
    input logic [31:0]      init_q,
    input logic             irq_o
);
    localparam logic [OFS_W-1:0] A_STATUS = OFS_W'(OFS_STATUS);

    // flags only appear after a period end
    p_flag_at_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !period_end |=> ((status_q & ~$past(status_q)) == 32'd0));

    // average moves only on a sample or a seed
    p_avg_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!period_end && !seed) |=> $stable(avg_q));

    // seeding loads the initial value
    p_seed_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        seed |=> (avg_q == $past(init_q)));

    // idle channel keeps an empty accumulator
    p_idle_empty_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (acc_q == 32'd0));

    // all-ones write empties the status when nothing new is raised
    p_clear_all_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (ofs == A_STATUS) && (wdata == 32'hFFFF_FFFF) && !period_end)
        |=> (status_q == 32'd0));

    // interrupt rises only after a period end or a register write
    p_irq_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> ($past(period_end) || $past(wr_en)));
endmodule

bind actmon_channel actmon_channel_checker #(.OFS_W(OFS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .period_end (period_end),
    .active     (active),
    .seed       (seed),
    .wr_en      (wr_en),
    .ofs        (ofs),
    .wdata      (wdata),
    .status_q   (status_q),
    .avg_q      (avg_q),
    .acc_q      (acc_q),
    .init_q     (init_q),
    .irq_o      (irq_o)
);

// File: tb/actmon_top_bench.sv
module actmon_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ms_tick = 1'b0;
    logic [1:0]  event_in = '0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    bit done = 1'b0;

    // reference state
    bit [31:0] m_ctrl[2], m_up[2], m_lo[2], m_init[2], m_ahi[2], m_alo[2], m_wt[2];
    bit [31:0] m_avg[2], m_st[2], m_acc[2];
    bit [2:0]  m_runh[2], m_runl[2];
    bit [7:0]  m_period = 8'd11;
    bit [7:0]  m_pcnt = 8'd0;

    actmon_top u_actmon_top (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .event_in(event_in),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq(irq)
    );

    always #2.5 clk = ~clk;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc == 150000 && !done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected finish", cyc);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    function automatic bit [11:0] cha(int c, int o);
        return 12'(12'h1C0 + c * 12'h40 + o);
    endfunction

    function automatic bit m_irq(int c);
        bit [31:0] s = m_st[c];
        bit [31:0] k = m_ctrl[c];
        return (s[31] & k[30]) | (s[30] & k[29]) | (s[29] & k[21]) | (s[28] & k[20]);
    endfunction

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference behaviour of one clock edge
    task automatic model_edge(bit tick, bit [1:0] ev, bit wr, bit [11:0] a, bit [31:0] d);
        bit pe;
        pe = tick && (m_pcnt >= m_period);
        if (tick) m_pcnt = pe ? 8'd0 : m_pcnt + 8'd1;
        for (int c = 0; c < 2; c++) begin
            bit [31:0] cr;
            bit        act, hit;
            longint    tot, diff, avn;
            bit [31:0] setb;
            bit [11:0] base;
            cr = m_ctrl[c];
            act = cr[31] & cr[18];
            setb = '0;
            base = cha(c, 0);
            hit = wr && (a[11:6] == base[11:6]);
            tot = longint'(m_acc[c]) + ((act && ev[c]) ? longint'(m_wt[c]) : 0);
            if (tot > 64'hFFFF_FFFF) tot = 64'hFFFF_FFFF;
            avn = longint'(m_avg[c]);
            if (!(cr[30] && act)) m_runh[c] = 0;
            else if (pe) begin
                if (tot > longint'(m_up[c])) begin
                    if (m_runh[c] == cr[28:26]) setb[31] = 1'b1; else m_runh[c]++;
                end else m_runh[c] = 0;
            end
            if (!(cr[29] && act)) m_runl[c] = 0;
            else if (pe) begin
                if (tot < longint'(m_lo[c])) begin
                    if (m_runl[c] == cr[25:23]) setb[30] = 1'b1; else m_runl[c]++;
                end else m_runl[c] = 0;
            end
            if (pe && act) begin
                diff = tot - longint'(m_avg[c]);
                avn = longint'(m_avg[c]) + (diff >>> (int'(cr[12:10]) + 1));
                if (avn > longint'(m_ahi[c])) setb[29] = 1'b1;
                if (avn < longint'(m_alo[c])) setb[28] = 1'b1;
                m_acc[c] = 0;
            end else begin
                m_acc[c] = act ? tot[31:0] : 32'd0;
            end
            if (hit && a[5:0] == 6'h24) m_st[c] = m_st[c] & ~d;
            m_st[c] |= setb;
            if (hit && a[5:0] == 6'h00 && d[31] && !cr[31]) m_avg[c] = m_init[c];
            else m_avg[c] = avn[31:0];
            if (hit) begin
                case (a[5:0])
                    6'h00: m_ctrl[c] = d;
                    6'h04: m_up[c] = d;
                    6'h08: m_lo[c] = d;
                    6'h0C: m_init[c] = d;
                    6'h10: m_ahi[c] = d;
                    6'h14: m_alo[c] = d;
                    6'h18: m_wt[c] = d;
                    default: ;
                endcase
            end
        end
        if (wr && a == 12'h004) m_period = d[7:0];
    endtask

    // one clock with the given inputs; returns at the next falling edge
    task automatic cycle(bit tick, bit [1:0] ev, bit wr, bit [11:0] a, bit [31:0] d);
        ms_tick = tick; event_in = ev; bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        model_edge(tick, ev, wr, a, d);
        @(negedge clk);
        ms_tick = 1'b0; event_in = '0; bus_wr = 1'b0;
    endtask

    task automatic wr(bit [11:0] a, bit [31:0] d);
        cycle(1'b0, 2'b00, 1'b1, a, d);
    endtask

    task automatic rd_chk(string tag, bit [11:0] a, bit [31:0] exp);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp);
    endtask

    // n event cycles on the masked channels followed by one full period of ticks
    task automatic period_with(int n, bit [1:0] mask);
        for (int i = 0; i < n; i++) cycle(1'b0, mask, 1'b0, 12'h0, 32'h0);
        for (int i = 0; i <= int'(m_period); i++) cycle(1'b1, 2'b00, 1'b0, 12'h0, 32'h0);
    endtask

    localparam bit [31:0] EN = 32'h8000_0000;
    localparam bit [31:0] PER = 32'h0004_0000;

    initial begin
        bit [31:0] ctl0;
        void'($urandom(32'd20240611));
        for (int c = 0; c < 2; c++) begin
            m_ctrl[c] = 0; m_up[c] = 0; m_lo[c] = 0; m_init[c] = 0; m_ahi[c] = 0;
            m_alo[c] = 0; m_wt[c] = 32'd1024; m_avg[c] = 0; m_st[c] = 0; m_acc[c] = 0;
            m_runh[c] = 0; m_runl[c] = 0;
        end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset values
        rd_chk("R1 ctrl", cha(0, 'h00), 32'h0);
        rd_chk("R1 weight", cha(0, 'h18), 32'd1024);
        rd_chk("R1 period", 12'h004, 32'd11);
        rd_chk("R1 summary", 12'h000, 32'h0);
        rd_chk("R1 avg", cha(1, 'h20), 32'h0);
        check("R1 irq", {31'b0, irq}, 32'h0);

        // channel 0 setup, R11 map and R5 seeding
        wr(12'h004, 32'd2);
        wr(cha(0, 'h18), 32'd100);
        wr(cha(0, 'h0C), 32'd3000);
        wr(cha(0, 'h04), 32'd500);
        wr(cha(0, 'h10), 32'd5000);
        ctl0 = EN | PER | (32'd2 << 26) | 32'h4000_0000;
        wr(cha(0, 'h00), ctl0);
        rd_chk("R11 ctrl readback", cha(0, 'h00), ctl0);
        rd_chk("R5 seeded avg", cha(0, 'h20), 32'd3000);

        // R2 period length, R4 average
        for (int i = 0; i < 10; i++) cycle(1'b0, 2'b01, 1'b0, 12'h0, 32'h0);
        cycle(1'b1, 2'b00, 1'b0, 12'h0, 32'h0);
        cycle(1'b1, 2'b00, 1'b0, 12'h0, 32'h0);
        rd_chk("R2 no sample before last tick", cha(0, 'h20), 32'd3000);
        cycle(1'b1, 2'b00, 1'b0, 12'h0, 32'h0);
        rd_chk("R4 avg after one sample", cha(0, 'h20), 32'd2000);
        rd_chk("R7 no fire after one", cha(0, 'h24), 32'h0);
        period_with(10, 2'b01);
        rd_chk("R7 no fire after two", cha(0, 'h24), 32'h0);
        period_with(10, 2'b01);
        rd_chk("R7 fire on third", cha(0, 'h24), 32'h8000_0000);
        rd_chk("R4 avg after three", cha(0, 'h20), 32'd1250);
        rd_chk("R10 summary ch0", 12'h000, 32'h0400_0000);
        check("R10 irq high", {31'b0, irq}, 32'h1);

        // R9 clear
        wr(cha(0, 'h24), 32'hFFFF_FFFF);
        rd_chk("R9 cleared", cha(0, 'h24), 32'h0);
        check("R9 irq low", {31'b0, irq}, 32'h0);

        // R3 idle channel ignores events
        wr(cha(0, 'h00), ctl0 & ~PER);
        period_with(10, 2'b01);
        rd_chk("R3 avg unchanged", cha(0, 'h20), 32'd1250);
        rd_chk("R3 status unchanged", cha(0, 'h24), 32'h0);

        // R7 run restarts on a miss
        wr(cha(0, 'h00), ctl0);
        period_with(10, 2'b01);
        period_with(2, 2'b01);
        period_with(10, 2'b01);
        period_with(10, 2'b01);
        rd_chk("R7 restart after miss", cha(0, 'h24), 32'h0);
        period_with(10, 2'b01);
        rd_chk("R7 fire after new run", cha(0, 'h24), 32'h8000_0000);
        wr(cha(0, 'h24), 32'hFFFF_FFFF);

        // R8 and R6 on channel 1
        wr(cha(1, 'h08), 32'd5);
        wr(cha(1, 'h14), 32'd1);
        wr(cha(1, 'h00), EN | PER | (32'd1 << 10) | (32'd1 << 23) | 32'h2000_0000 | 32'h0010_0000);
        period_with(0, 2'b00);
        rd_chk("R6 avg below after one", cha(1, 'h24), 32'h1000_0000);
        rd_chk("R10 summary ch1", 12'h000, 32'h0200_0000);
        period_with(0, 2'b00);
        rd_chk("R8 below fires on second", cha(1, 'h24), 32'h5000_0000);

        // random phase against the reference
        for (int blk = 0; blk < 12; blk++) begin
            wr(12'h004, $urandom_range(0, 4));
            for (int c = 0; c < 2; c++) begin
                wr(cha(c, 'h18), $urandom_range(1, 60));
                wr(cha(c, 'h04), $urandom_range(0, 900));
                wr(cha(c, 'h08), $urandom_range(0, 900));
                wr(cha(c, 'h10), $urandom_range(0, 900));
                wr(cha(c, 'h14), $urandom_range(0, 900));
                wr(cha(c, 'h0C), $urandom_range(0, 900));
                if ($urandom_range(0, 2) == 0) wr(cha(c, 'h00), 32'h0);
                wr(cha(c, 'h00), ($urandom() & 32'h7EF4_1C00) | EN | PER);
            end
            for (int i = 0; i < 300; i++) begin
                if ($urandom_range(0, 60) == 0)
                    cycle(1'(($urandom_range(0, 1))), 2'($urandom()), 1'b1,
                          cha($urandom_range(0, 1), 'h24), $urandom());
                else
                    cycle(1'($urandom_range(0, 1)), 2'($urandom()), 1'b0, 12'h0, 32'h0);
                check("R10 irq vs reference", {31'b0, irq}, {31'b0, m_irq(0) | m_irq(1)});
                if (i % 25 == 0) begin
                    for (int c = 0; c < 2; c++) begin
                        rd_chk("R4 avg vs reference", cha(c, 'h20), m_avg[c]);
                        rd_chk("R6 R7 R8 R9 status vs reference", cha(c, 'h24), m_st[c]);
                    end
                    rd_chk("R10 summary vs reference", 12'h000,
                           {5'b0, m_irq(0), m_irq(1), 25'b0});
                end
            end
        end

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule